// File: doc/BRIEF.md
# Stochastic Decode Cycle and Retry Sequencer

This block controls how a stochastic LDPC frame decode is run. While a decode is active, every clock is one decoding cycle: one bit goes from the variable nodes to the check nodes and comes back. A node array outside this block does the decoding. This block counts the decoding cycles and watches a flag that says every parity check is satisfied. When that flag is seen, the attempt stops at once. If the flag is never seen, the attempt stops at a fixed cycle limit.

When an attempt fails and retries remain, the sequencer restarts the node array from its initial state. The array decodes the same received frame again. The per-attempt cycle limit does not change on a retry. The random generators in the array are not reseeded, so each new attempt sees a different random sequence. That is the only difference between attempts.

A stage code goes to the node array and selects the relaxation factor. It steps by decoding-cycle count: quarter first, then eighth, then sixteenth. No data flows through this block, so every pin is a plain control or status signal and none uses a valid/ready handshake.

Top module: `sdec_seq_ctrl`

## Requirements
- R1: Reset state. After reset, `restart_o`, `done_o` and `success_o` are 0, and `attempt_o`, `cycle_o` and `stage_o` are 0.
- R2: Start of a frame. In the idle or done state, `start_i` high at a clock edge makes `restart_o` high for exactly the next clock. At the same time `attempt_o` and `cycle_o` go to 0 and `done_o` and `success_o` go to 0.
- R3: Cycle counting. On the clock after the restart pulse, the first decoding cycle runs with `cycle_o` = 0. `cycle_o` then rises by one on each clock while the attempt runs.
- R4: Early end on a valid codeword. `syndrome_ok_i` is sampled once in every running decoding cycle. If it is high, `done_o` and `success_o` are both 1 from the next clock on, and `cycle_o` and `attempt_o` freeze. They hold until the next accepted start.
- R5: Cycle limit. An attempt runs at most CYC_LIMIT decoding cycles, so `cycle_o` never goes above CYC_LIMIT-1. The default limit is 1000, and 160 is also a supported setting.
- R6: Retry. An attempt can fail at cycle CYC_LIMIT-1 while attempts remain. After such a failure, the next clock gives a one-clock `restart_o` pulse. On that clock `attempt_o` rises by one and `cycle_o` and `stage_o` return to 0. The new attempt gets the same cycle limit.
- R7: Final failure. When attempt MAX_ATTEMPTS-1 reaches its cycle limit without a valid codeword, `done_o` goes to 1 and `success_o` stays 0 from the next clock on.
- R8: Relaxation schedule. `stage_o` follows the current `cycle_o`:
  - 0 (factor 1/4) for cycles 0 to 33
  - 1 (factor 1/8) for cycles 34 to 110
  - 2 (factor 1/16) from cycle 111 on
- R9: `syndrome_ok_i` has no effect while no decoding cycle is running, that is when idle, on the restart clock, or when done. It neither sets `done_o` nor changes `success_o`.
- R10: `start_i` has no effect while an attempt is running. The cycle count continues and no restart pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one decoding cycle per clock while running |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin decoding a newly received frame |
| syndrome_ok_i | input | 1 | All parity checks satisfied in the current decoding cycle |
| restart_o | output | 1 | One-clock pulse that returns the node array to its initial state |
| stage_o | output | 2 | Relaxation stage code: 0 = 1/4, 1 = 1/8, 2 = 1/16 |
| done_o | output | 1 | Frame finished (level, held until next start) |
| success_o | output | 1 | Frame finished with a valid codeword |
| attempt_o | output | AW | Index of the current or final attempt, from 0 |
| cycle_o | output | CW | Decoding-cycle index within the current attempt |

## Verification
Each result appears a fixed number of clocks after the input that causes it:
- The restart pulse and the cleared counts appear one clock after an accepted start.
- The first decoding cycle, with count 0, follows one clock after that.
- `done_o` and `success_o` appear one clock after the decoding cycle in which the syndrome flag is sampled high.
- A retry pulse appears one clock after cycle CYC_LIMIT-1.
- `stage_o` follows `cycle_o` in the same clock.

The bench drives inputs shortly after the falling edge. For each clock it pushes the expected output state after the coming rising edge. It compares that state on the following falling edge, so every expectation lines up with exactly one register stage.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RESTART = 2'd1,
    PH_RUN     = 2'd2,
    PH_DONE    = 2'd3
  } phase_t;

  localparam int unsigned STAGE_W = 2;

  typedef enum logic [STAGE_W-1:0] {
    STG_QUARTER   = 2'd0,
    STG_EIGHTH    = 2'd1,
    STG_SIXTEENTH = 2'd2
  } stage_t;

endpackage

// File: rtl/sdec_cycle_ctr.sv
module sdec_cycle_ctr #(
  parameter int unsigned CYC_LIMIT = 1000,
  parameter int unsigned CW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);

  localparam logic [CW-1:0] LAST_VAL = CW'(CYC_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/sdec_attempt_ctr.sv
module sdec_attempt_ctr #(
  parameter int unsigned MAX_ATTEMPTS = 4,
  parameter int unsigned AW           = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] att_o,
  output logic          final_o
);

  localparam logic [AW-1:0] FINAL_VAL = AW'(MAX_ATTEMPTS - 1);

  logic [AW-1:0] att_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q <= '0;
    end else if (clr_i) begin
      att_q <= '0;
    end else if (inc_i) begin
      att_q <= att_q + 1'b1;
    end
  end

  assign att_o   = att_q;
  assign final_o = (att_q == FINAL_VAL);

endmodule

// File: rtl/sdec_stage_map.sv
module sdec_stage_map
  import sdec_pkg::*;
#(
  parameter int unsigned CW          = 10,
  parameter int unsigned STG1_START  = 34,
  parameter int unsigned STG2_START  = 111
) (
  input  logic [CW-1:0]      cyc_i,
  output logic [STAGE_W-1:0] stage_o
);

  localparam int unsigned NBOUND = 2;
  localparam int unsigned BOUNDS [NBOUND] = '{STG1_START, STG2_START};

  logic [NBOUND-1:0] past_bound;

  for (genvar g = 0; g < NBOUND; g++) begin : g_bound
    assign past_bound[g] = ({1'b0, cyc_i} >= (CW+1)'(BOUNDS[g]));
  end

  always_comb begin
    stage_o = '0;
    for (int k = 0; k < NBOUND; k++) begin
      if (past_bound[k]) stage_o = stage_o + 1'b1;
    end
  end

endmodule

// File: rtl/sdec_seq_ctrl.sv
module sdec_seq_ctrl
  import sdec_pkg::*;
#(
  parameter int unsigned CYC_LIMIT    = 1000,
  parameter int unsigned MAX_ATTEMPTS = 4,
  parameter int unsigned STG1_START   = 34,
  parameter int unsigned STG2_START   = 111,
  localparam int unsigned CW = (CYC_LIMIT > 2) ? $clog2(CYC_LIMIT) : 1,
  localparam int unsigned AW = (MAX_ATTEMPTS > 2) ? $clog2(MAX_ATTEMPTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               syndrome_ok_i,
  output logic               restart_o,
  output logic [STAGE_W-1:0] stage_o,
  output logic               done_o,
  output logic               success_o,
  output logic [AW-1:0]      attempt_o,
  output logic [CW-1:0]      cycle_o
);

  phase_t phase_q, phase_d;
  logic   success_q;
  logic   running;
  logic   start_take;
  logic   hit;
  logic   cyc_last;
  logic   att_final;
  logic   retry;
  logic   give_up;

  assign running    = (phase_q == PH_RUN);
  assign start_take = start_i && ((phase_q == PH_IDLE) || (phase_q == PH_DONE));
  assign hit        = running && syndrome_ok_i;
  assign retry      = running && !syndrome_ok_i && cyc_last && !att_final;
  assign give_up    = running && !syndrome_ok_i && cyc_last && att_final;

  sdec_cycle_ctr #(
    .CYC_LIMIT (CYC_LIMIT),
    .CW        (CW)
  ) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_take || retry),
    .adv_i  (running && !syndrome_ok_i && !cyc_last),
    .cnt_o  (cycle_o),
    .last_o (cyc_last)
  );

  sdec_attempt_ctr #(
    .MAX_ATTEMPTS (MAX_ATTEMPTS),
    .AW           (AW)
  ) u_att (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_take),
    .inc_i   (retry),
    .att_o   (attempt_o),
    .final_o (att_final)
  );

  sdec_stage_map #(
    .CW         (CW),
    .STG1_START (STG1_START),
    .STG2_START (STG2_START)
  ) u_stage (
    .cyc_i   (cycle_o),
    .stage_o (stage_o)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE, PH_DONE: if (start_take) phase_d = PH_RESTART;
      PH_RESTART:       phase_d = PH_RUN;
      PH_RUN: begin
        if (hit || give_up) phase_d = PH_DONE;
        else if (retry)     phase_d = PH_RESTART;
      end
      default:          phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      success_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (start_take)  success_q <= 1'b0;
      else if (hit)    success_q <= 1'b1;
    end
  end

  assign restart_o = (phase_q == PH_RESTART);
  assign done_o    = (phase_q == PH_DONE);
  assign success_o = success_q;

endmodule

// File: rtl/sdec_seq_ctrl_chk.sv
module sdec_seq_ctrl_chk #(
  parameter int unsigned CYC_LIMIT    = 1000,
  parameter int unsigned MAX_ATTEMPTS = 4,
  parameter int unsigned CW           = 10,
  parameter int unsigned AW           = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          syndrome_ok_i,
  input logic          restart_o,
  input logic [1:0]    stage_o,
  input logic          done_o,
  input logic          success_o,
  input logic [AW-1:0] attempt_o,
  input logic [CW-1:0] cycle_o,
  input logic          running
);

  logic at_last;
  logic at_final;
  assign at_last  = (int'(cycle_o) == int'(CYC_LIMIT) - 1);
  assign at_final = (int'(attempt_o) == int'(MAX_ATTEMPTS) - 1);

  p_restart_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);

  p_cycle_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running) |-> (cycle_o == $past(cycle_o) + CW'(1)));

  p_hit_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && syndrome_ok_i) |=> (done_o && success_o));

  p_success_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    success_o |-> done_o);

  p_cycle_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cycle_o) < int'(CYC_LIMIT));

  p_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !syndrome_ok_i && at_last && !at_final)
      |=> (restart_o && attempt_o == $past(attempt_o) + AW'(1)));

  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (cycle_o == '0 && stage_o == 2'd0));

  p_give_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !syndrome_ok_i && at_last && at_final) |=> (done_o && !success_o));

  p_stage_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running && stage_o != $past(stage_o))
      |-> (stage_o == $past(stage_o) + 2'd1));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart_o && !done_o && !start_i) |=> !done_o);

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_i && !syndrome_ok_i && !at_last) |=> (running && !restart_o));

endmodule

bind sdec_seq_ctrl sdec_seq_ctrl_chk #(
  .CYC_LIMIT    (CYC_LIMIT),
  .MAX_ATTEMPTS (MAX_ATTEMPTS),
  .CW           (CW),
  .AW           (AW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .syndrome_ok_i (syndrome_ok_i),
  .restart_o     (restart_o),
  .stage_o       (stage_o),
  .done_o        (done_o),
  .success_o     (success_o),
  .attempt_o     (attempt_o),
  .cycle_o       (cycle_o),
  .running       (running)
);

// File: tb/sdec_seq_ctrl_bench.sv
`timescale 1ns/100ps
module sdec_seq_ctrl_bench;

  localparam int L  = 160;
  localparam int M  = 3;
  localparam int CW = $clog2(L);
  localparam int AW = $clog2(M);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic synd = 1'b0;
  logic          restart, done, success;
  logic [1:0]    stage;
  logic [AW-1:0] attempt;
  logic [CW-1:0] cycle;

  always #2.5 clk = ~clk;

  sdec_seq_ctrl #(.CYC_LIMIT(L), .MAX_ATTEMPTS(M)) u_sdec_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .syndrome_ok_i(synd),
    .restart_o(restart), .stage_o(stage), .done_o(done), .success_o(success),
    .attempt_o(attempt), .cycle_o(cycle)
  );

  typedef struct {
    logic rs; logic dn; logic sc; int att; int cyc; int stg; string tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  bit ended = 0;
  int m_ph = 0, m_cyc = 0, m_att = 0;
  logic m_sc = 1'b0;

  function automatic int stage_for(int c);
    return (c < 34) ? 0 : (c < 111) ? 1 : 2;
  endfunction

  function automatic string auto_tag();
    if (m_ph == 3) return "R7";
    if (m_ph == 1) return "R6";
    if ((m_cyc >= 33 && m_cyc <= 35) || (m_cyc >= 110 && m_cyc <= 112)) return "R8";
    return "R5";
  endfunction

  task automatic step(input logic st, input logic sy, input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    start = st;
    synd  = sy;
    case (m_ph)
      0, 3: if (st) begin m_ph = 1; m_cyc = 0; m_att = 0; m_sc = 1'b0; end
      1: m_ph = 2;
      2: begin
        if (sy) begin m_ph = 3; m_sc = 1'b1; end
        else if (m_cyc == L - 1) begin
          if (m_att == M - 1) m_ph = 3;
          else begin m_att++; m_cyc = 0; m_ph = 1; end
        end else m_cyc++;
      end
      default: m_ph = 0;
    endcase
    e.rs = (m_ph == 1); e.dn = (m_ph == 3); e.sc = m_sc;
    e.att = m_att; e.cyc = m_cyc; e.stg = stage_for(m_cyc);
    e.tag = (tag == "") ? auto_tag() : tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #0.5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (restart !== e.rs || done !== e.dn || success !== e.sc ||
            int'(attempt) != e.att || int'(cycle) != e.cyc || int'(stage) != e.stg) begin
          n_bad++;
          $display("FAIL %s: got rs=%0b dn=%0b sc=%0b att=%0d cyc=%0d stg=%0d, expected rs=%0b dn=%0b sc=%0b att=%0d cyc=%0d stg=%0d",
                   e.tag, restart, done, success, attempt, cycle, stage,
                   e.rs, e.dn, e.sc, e.att, e.cyc, e.stg);
        end
      end
    end
  end

  task automatic finish_run();
    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no end of run, expected completion");
      finish_run();
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset/idle state
    repeat (3) step(1'b0, 1'b0, "R1");
    // R9: syndrome while idle is ignored
    repeat (3) step(1'b0, 1'b1, "R9");
    // R2 start, R3 counting, R4 early success
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R3");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, "R4");
    for (int i = 0; i < 4; i++) step(1'b0, logic'(i % 2), (i % 2) ? "R9" : "R4");
    // R5/R6/R7/R8 full failure, R10 start ignored while running
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R3");
    for (int i = 0; i < M * (L + 1) - 1; i++) begin
      if (i == 6) step(1'b1, 1'b0, "R10");
      else        step(1'b0, 1'b0, "");
    end
    step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, "R7");
    // R9 syndrome on restart clock ignored; success on second attempt
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b1, "R9");
    for (int i = 0; i < L; i++) step(1'b0, 1'b0, "");
    step(1'b0, 1'b0, "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, "R4");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule